// File: doc/BRIEF.md
# UART Interrupt Enable, Mask and Status Controller

This block is the interrupt front end of a serial port. It receives one-cycle event pulses from the receive and transmit paths, filters them through a mask register, and latches the survivors into a sticky status register. A single interrupt line is high while any latched status bit is set. Software acknowledges an event by writing a one to its status bit.

The mask has no direct write path. It is changed through two write-only registers. A one written to the enable register sets the matching mask bit. A one written to the disable register clears it. Both of these registers read back as zero. A separate channel status view shows the live receive-trigger, receive-empty, transmit-empty and transmit-full levels, whatever the mask holds.

Access is through a plain single-cycle register port with no back-pressure. A write takes effect at the clock edge on which `reg_wr` is high. Read data is combinational from `reg_addr`. Word addresses are: 0 enable (set), 1 disable (clear), 2 mask, 3 status, 4 channel status. Reads of any other address return zero.

Top module: `uart_irq_ctrl`

## Requirements
- R1: A write to address 0 sets every mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R2: A write to address 1 clears every mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R3: Reads of addresses 0 and 1 always return zero. Reads of address 2 return the mask and reads of address 3 return the status.
- R4: An event pulse on bit i sets status bit i at the next edge only if mask bit i is set at that edge. A masked event leaves status unchanged. Bit assignment: 0 receive trigger, 1 receive empty, 2 receive full, 3 transmit empty, 4 transmit full, 5 overrun, 6 framing error, 7 parity error, 8 receive timeout, 9 to 12 spare.
- R5: A write to address 3 clears each status bit whose write-data bit is 1. Status bits whose write-data bit is 0 are left unchanged.
- R6: If an enabled event and a clearing write to the same status bit fall on the same edge, that bit is set after the edge.
- R7: Only bits 12:0 exist. Write-data bits 31:13 have no effect, and read data bits 31:13 are always zero.
- R8: Address 4 returns the live levels in the same cycle, independent of the mask: bit 0 receive trigger, bit 1 receive empty, bit 3 transmit empty, bit 4 transmit full. All other bits are zero.
- R9: `irq` is high exactly when at least one status bit is set.
- R10: After reset the mask and status are zero and `irq` is low. Writes to addresses 2 and 4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse | input | 13 | One-cycle event pulses, bit map as in R4 |
| lvl_rx_trig | input | 1 | Live receive-trigger level |
| lvl_rx_empty | input | 1 | Live receive-empty level |
| lvl_tx_empty | input | 1 | Live transmit-empty level |
| lvl_tx_full | input | 1 | Live transmit-full level |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can land on the same edge. One is an enabled event pulse on a status bit. The other is a write-one-to-clear of that bit. The bench drives a status write and a pulse on the same bits in one cycle, and expects the bit to remain set. A second case pairs an event with a disable write to its mask bit. Here the event is still judged against the mask value held before that edge. A behavioural reference model compares both results with read data and `irq` on every clock.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int IRQ_W  = 13;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_SET  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CLR  = 3'd1;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
  localparam logic [ADDR_W-1:0] A_CHAN = 3'd4;

  localparam int B_RX_TRIG  = 0;
  localparam int B_RX_EMPTY = 1;
  localparam int B_TX_EMPTY = 3;
  localparam int B_TX_FULL  = 4;
endpackage

// File: rtl/uirq_mask.sv
module uirq_mask #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wbits,
  output logic [W-1:0] mask_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_o <= '0;
    else if (set_we) mask_o <= mask_o | wbits;
    else if (clr_we) mask_o <= mask_o & ~wbits;
  end

  // R1
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((mask_o & $past(wbits)) == $past(wbits)));
  // R2
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((mask_o & $past(wbits)) == '0));
  // R2
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we || clr_we) |=> ((mask_o & ~$past(wbits)) == ($past(mask_o) & ~$past(wbits))));
endmodule

// File: rtl/uirq_status.sv
module uirq_status #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] mask_i,
  input  logic         clr_we,
  input  logic [W-1:0] wbits,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] hit;
  logic [W-1:0] drop;

  assign hit  = evt_i & mask_i;
  assign drop = clr_we ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_o <= '0;
    else        stat_o <= (stat_o & ~drop) | hit;
  end

  // R4 R6
  stat_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_o & $past(evt_i & mask_i)) == $past(evt_i & mask_i)));
  // R4
  stat_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_o & ~$past(stat_o) & ~$past(mask_i)) == '0));
  // R5
  stat_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && ((wbits & evt_i) == '0)) |=> ((stat_o & $past(wbits)) == '0));
endmodule

// File: rtl/uirq_rdmux.sv
module uirq_rdmux
  import uirq_pkg::*;
#(
  parameter int W  = IRQ_W,
  parameter int DW = DATA_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      mask_i,
  input  logic [W-1:0]      stat_i,
  input  logic [W-1:0]      chan_i,
  output logic [DW-1:0]     rdata
);
  localparam int PAD = DW - W;

  always_comb begin
    unique case (addr)
      A_MASK:  rdata = {{PAD{1'b0}}, mask_i};
      A_STAT:  rdata = {{PAD{1'b0}}, stat_i};
      A_CHAN:  rdata = {{PAD{1'b0}}, chan_i};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IRQ_W-1:0]  evt_pulse,
  input  logic              lvl_rx_trig,
  input  logic              lvl_rx_empty,
  input  logic              lvl_tx_empty,
  input  logic              lvl_tx_full,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [IRQ_W-1:0] wbits, mask_q, stat_q, chan;
  logic set_we, clr_we, ack_we;

  assign wbits  = reg_wdata[IRQ_W-1:0];
  assign set_we = reg_wr && (reg_addr == A_SET);
  assign clr_we = reg_wr && (reg_addr == A_CLR);
  assign ack_we = reg_wr && (reg_addr == A_STAT);

  always_comb begin
    chan = '0;
    chan[B_RX_TRIG]  = lvl_rx_trig;
    chan[B_RX_EMPTY] = lvl_rx_empty;
    chan[B_TX_EMPTY] = lvl_tx_empty;
    chan[B_TX_FULL]  = lvl_tx_full;
  end

  uirq_mask #(.W(IRQ_W)) mask_u (
    .clk(clk), .rst_n(rst_n), .set_we(set_we), .clr_we(clr_we),
    .wbits(wbits), .mask_o(mask_q));

  uirq_status #(.W(IRQ_W)) stat_u (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_pulse), .mask_i(mask_q),
    .clr_we(ack_we), .wbits(wbits), .stat_o(stat_q));

  uirq_rdmux #(.W(IRQ_W), .DW(DATA_W)) rd_u (
    .addr(reg_addr), .mask_i(mask_q), .stat_i(stat_q), .chan_i(chan),
    .rdata(reg_rdata));

  assign irq = |stat_q;

  // R3
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_SET || reg_addr == A_CLR) |-> (reg_rdata == '0));
  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:IRQ_W] == '0);
  // R9
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(ack_we));
endmodule

// File: tb/uart_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module uart_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] evt_pulse = '0;
  logic        lvl_rx_trig = 0, lvl_rx_empty = 0, lvl_tx_empty = 0, lvl_tx_full = 0;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R10";
  int m_mask = 0, m_stat = 0;

  always #2 clk = ~clk;

  uart_irq_ctrl dut_i (.*);

  // behavioural reference model
  always @(posedge clk) begin
    if (rst_n) begin
      int w, nm, ns;
      w  = int'(reg_wdata) & 32'h1FFF;
      nm = m_mask;
      ns = m_stat;
      if (reg_wr && reg_addr == 3'd0) nm = m_mask | w;
      if (reg_wr && reg_addr == 3'd1) nm = m_mask & ~w;
      if (reg_wr && reg_addr == 3'd3) ns = ns & ~w;
      ns = ns | (int'(evt_pulse) & m_mask);
      m_mask = nm;
      m_stat = ns;
    end
  end

  function automatic int exp_rd();
    case (reg_addr)
      3'd2: return m_mask;
      3'd3: return m_stat;
      3'd4: return (lvl_rx_trig ? 1 : 0) | (lvl_rx_empty ? 2 : 0) |
                   (lvl_tx_empty ? 8 : 0) | (lvl_tx_full ? 16 : 0);
      default: return 0;
    endcase
  endfunction

  task automatic compare();
    n_run++;
    if (reg_rdata !== 32'(exp_rd())) begin
      n_fail++;
      $display("FAIL %s rdata addr=%0d actual=%h expected=%h", cur_req, reg_addr, reg_rdata, exp_rd());
    end
    n_run++;
    if (irq !== (m_stat != 0)) begin
      n_fail++;
      $display("FAIL %s irq actual=%b expected=%b", cur_req, irq, (m_stat != 0));
    end
  endtask

  // one clock: drive, advance, compare at negedge, release pulses/strobe
  task automatic cyc(input bit wr, input logic [2:0] a, input logic [31:0] d, input logic [12:0] ev);
    reg_wr = wr; reg_addr = a; reg_wdata = d; evt_pulse = ev;
    @(negedge clk);
    compare();
    reg_wr = 0; evt_pulse = '0;
  endtask

  task automatic rd(input logic [2:0] a);
    cyc(0, a, 32'h0, '0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    cur_req = "R10"; rd(3'd2); rd(3'd3);
    // R1 set bits, zero bits untouched
    cur_req = "R1";
    cyc(1, 3'd0, 32'h0000_0009, '0); rd(3'd2);
    cyc(1, 3'd0, 32'h0000_0180, '0); rd(3'd2);
    // R2 clear bits
    cur_req = "R2";
    cyc(1, 3'd1, 32'h0000_0008, '0); rd(3'd2);
    // R3 write-only registers read zero
    cur_req = "R3"; rd(3'd0); rd(3'd1);
    // R4 masked vs enabled events
    cur_req = "R4";
    cyc(0, 3'd3, 0, 13'h0008); rd(3'd3);
    cyc(0, 3'd3, 0, 13'h0181); rd(3'd3);
    // R9 irq follows status
    cur_req = "R9"; rd(3'd3);
    // R5 write one to clear, zeros kept
    cur_req = "R5";
    cyc(1, 3'd3, 32'h0000_0080, '0); rd(3'd3);
    cyc(1, 3'd3, 32'h0000_0101, '0); rd(3'd3);
    // R6 event and clear on same edge
    cur_req = "R6";
    cyc(1, 3'd3, 32'h0000_0180, 13'h0180); rd(3'd3);
    cyc(1, 3'd1, 32'h0000_0001, 13'h0001); rd(3'd3);
    // R7 upper bits ignored
    cur_req = "R7";
    cyc(1, 3'd0, 32'hFFFF_E000, '0); rd(3'd2);
    cyc(1, 3'd3, 32'hFFFF_E000, '0); rd(3'd3);
    // R10 writes to mask and channel addresses ignored
    cur_req = "R10";
    cyc(1, 3'd2, 32'h0000_1FFF, '0); rd(3'd2);
    cyc(1, 3'd4, 32'h0000_1FFF, '0); rd(3'd2);
    // R8 channel status independent of mask
    cur_req = "R8";
    cyc(1, 3'd1, 32'h0000_1FFF, '0);
    for (int k = 0; k < 16; k++) begin
      lvl_rx_trig = k[0]; lvl_rx_empty = k[1]; lvl_tx_empty = k[2]; lvl_tx_full = k[3];
      rd(3'd4);
    end
    // mixed traffic
    cur_req = "R4";
    for (int k = 0; k < 300; k++) begin
      logic [2:0] a;
      a = 3'($urandom_range(0, 4));
      cyc(1'($urandom), a, $urandom, 13'($urandom) & 13'($urandom));
    end
    cur_req = "R9";
    cyc(1, 3'd3, 32'h0000_1FFF, '0); rd(3'd3);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule